// File: doc/BRIEF.md
# Tape Drive Command Decoder

This block takes command bytes that a host writes to one of four tape drive units and decides whether the command starts an operation. The low six bits of the byte select a function, and the top two bits are interrupt arming bits. A legal function is accepted only if several conditions hold. The addressed drive must have a medium loaded. A write-type function must not target a write-protected drive. The drive must not be in the middle of an operation, unless that operation has already reached its stopping phase. When a command is accepted, the block loads the initial controller state for that function and stores the function as the unit's current command. It clears the unit's tape flags. It sends a one-cycle start strobe, carrying the unit and the function, to the per-unit operation sequencer. It also cancels whatever the other drives are doing, except a rewind.

A separate clear function resets the controller and every unit, whatever the state of the addressed drive. The block also assembles the status byte that the host reads for a selected unit. This byte merges the controller-wide flags with that unit's own flags. A drive with no medium reports a device-unavailable bit instead of its own flags.

The sequencer, which is outside this block, reports back through one update port. This port can rewrite a unit's flags, the controller flags or the transfer flag, and it can retire a unit's stored command.

Top module: `tape_cmd_decoder`

## Requirements
- R1: Only the function codes 0x11 (backspace), 0x13 (space file reverse), 0x21 (read), 0x22 (write), 0x23 (space file forward), 0x30 (write file mark) and 0x38 (rewind) can start an operation. Every other code except 0x20 produces no start strobe and leaves the status byte unchanged.
- R2: Code 0x20 (clear) produces a one-cycle `clr_o` pulse and no start, even for a drive with no medium. Afterwards the controller status is busy only and the transfer flag is 0. Every stored command is 0, and every unit has no-motion set and keeps its end-of-tape bit.
- R3: A command to a unit whose `unit_present_i` bit is 0 is ignored.
- R4: Write (0x22) and write file mark (0x30) are ignored on a unit whose `unit_wprot_i` bit is 1. Other functions on that unit are accepted.
- R5: A command to a unit with `unit_active_i` set is ignored unless `unit_stopping_i` is also set for that unit.
- R6: On acceptance, `cancel_o` pulses for every other unit that is active and whose stored command is not rewind (0x38), and those units' stored commands become 0. A unit running a rewind keeps its stored command.
- R7: On acceptance, write and rewind set the controller status to 0x00. Every other function sets it to busy only (0x08).
- R8: On acceptance, the transfer flag `xfer_o` becomes 1 for read and write and 0 for every other function.
- R9: An accepted command produces `start_o` high for exactly the cycle after the write, with `start_unit_o` and `start_func_o` set to the unit and the function. The unit's stored command becomes the function, and its tape flags become 0.
- R10: The status byte has these bits: error 0x80, end-of-file 0x40, end-of-tape 0x20, no-motion 0x10, busy 0x08, end-of-medium 0x04, exception 0x02 and device-unavailable 0x01. End-of-tape and no-motion come from the selected unit and appear only when it has a medium; without a medium 0x01 is set instead. Exception is set whenever error, end-of-file or no-motion is set. Controller flags written by the sequencer are kept only in bits 0x80, 0x40, 0x08 and 0x04.
- R11: After reset, the controller status is busy, every unit has no-motion set with end-of-tape clear, and every stored command is 0. The transfer flag and all strobes are 0.
- R12: Every command write except clear produces a one-cycle `arm_stb_o` with the unit number and bits 7:6 of the byte, whether or not the command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr_i | input | 1 | Host command write strobe |
| cmd_unit_i | input | 2 | Addressed unit |
| cmd_byte_i | input | 8 | Command byte (bits 7:6 arm, bits 5:0 function) |
| unit_present_i | input | 4 | Medium present, per unit |
| unit_wprot_i | input | 4 | Write protected, per unit |
| unit_active_i | input | 4 | Sequencer operation running, per unit |
| unit_stopping_i | input | 4 | Sequencer in a stop phase, per unit |
| seq_upd_i | input | 1 | Sequencer update strobe |
| seq_unit_i | input | 2 | Unit addressed by the update |
| seq_ust_i | input | 2 | New unit flags {end-of-tape, no-motion} |
| seq_done_i | input | 1 | With update: retire the unit's stored command |
| seq_ctl_we_i | input | 1 | With update: load controller flags |
| seq_ctl_i | input | 8 | Controller flags to load |
| seq_xfer_clr_i | input | 1 | With update: clear the transfer flag |
| stat_unit_i | input | 2 | Unit selected for the status byte |
| status_o | output | 8 | Assembled status byte |
| xfer_o | output | 1 | Transfer in progress |
| start_o | output | 1 | Start strobe to the sequencer |
| start_unit_o | output | 2 | Unit of the started operation |
| start_func_o | output | 6 | Function of the started operation |
| cancel_o | output | 4 | Cancel strobe, per unit |
| clr_o | output | 1 | Controller clear strobe |
| arm_stb_o | output | 1 | Interrupt arming strobe |
| arm_unit_o | output | 2 | Unit for the arming bits |
| arm_bits_o | output | 2 | Arming bits from the command byte |
| ucmd_o | output | 24 | Stored command per unit, unit 0 in bits 5:0 |

## Verification
The bench sweeps all 64 function codes. A decoder with a wrong legal set would start on a reserved code or refuse a real one. The clear test is sent to a drive with no medium, so a decoder that applies the unit checks to clear would leave the controller unreset. The same test also covers a decoder that wipes the end-of-tape bit. The cancel test makes one other drive busy with a read and another busy with a rewind. A design that cancels rewinds, cancels the issuing drive, or forgets to zero a cancelled unit's stored command shows a wrong cancel mask or a wrong stored command. Further tests cover write protection against write file mark as well as write, a busy drive against a stopping one, and the exception and device-unavailable bits in the status byte.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

  localparam int FW = 6;
  typedef logic [FW-1:0] func_t;

  localparam func_t F_BKSP = 6'h11;
  localparam func_t F_SKFR = 6'h13;
  localparam func_t F_CLR  = 6'h20;
  localparam func_t F_RD   = 6'h21;
  localparam func_t F_WR   = 6'h22;
  localparam func_t F_SKFF = 6'h23;
  localparam func_t F_WFM  = 6'h30;
  localparam func_t F_REW  = 6'h38;

  localparam logic [7:0] S_ERR  = 8'h80;
  localparam logic [7:0] S_EOF  = 8'h40;
  localparam logic [7:0] S_EOT  = 8'h20;
  localparam logic [7:0] S_NMTN = 8'h10;
  localparam logic [7:0] S_BSY  = 8'h08;
  localparam logic [7:0] S_EOM  = 8'h04;
  localparam logic [7:0] S_EXC  = 8'h02;
  localparam logic [7:0] S_DU   = 8'h01;

  localparam logic [7:0] S_CTL_MASK = S_ERR | S_EOF | S_BSY | S_EOM;
  localparam logic [7:0] S_EXC_SRC  = S_ERR | S_EOF | S_NMTN;

  // unit flags held as {eot, nmtn}
  typedef logic [1:0] uflags_t;

  function automatic logic func_legal(input func_t f);
    case (f)
      F_BKSP, F_SKFR, F_RD, F_WR, F_SKFF, F_WFM, F_REW: func_legal = 1'b1;
      default:                                         func_legal = 1'b0;
    endcase
  endfunction

  function automatic logic func_writes(input func_t f);
    func_writes = (f == F_WR) || (f == F_WFM);
  endfunction

  function automatic logic func_is_xfer(input func_t f);
    func_is_xfer = (f == F_RD) || (f == F_WR);
  endfunction

  function automatic logic [7:0] ctl_init(input func_t f);
    ctl_init = ((f == F_WR) || (f == F_REW)) ? 8'h00 : S_BSY;
  endfunction

  function automatic logic [7:0] build_status(input logic [7:0] ctl,
                                              input uflags_t  uf,
                                              input logic     present);
    logic [7:0] t;
    t = ctl & S_CTL_MASK;
    if (present) begin
      if (uf[1]) t = t | S_EOT;
      if (uf[0]) t = t | S_NMTN;
    end else begin
      t = t | S_DU;
    end
    if ((t & S_EXC_SRC) != 8'h00) t = t | S_EXC;
    build_status = t;
  endfunction

endpackage

// File: rtl/tcd_decode.sv
module tcd_decode
  import tcd_pkg::*;
#(
  parameter int NU = 4,
  parameter int UW = $clog2(NU)
) (
  input  logic                cmd_wr,
  input  logic [UW-1:0]       cmd_unit,
  input  logic [7:0]          cmd_byte,
  input  logic [NU-1:0]       present,
  input  logic [NU-1:0]       wprot,
  input  logic [NU-1:0]       active,
  input  logic [NU-1:0]       stopping,
  input  logic [NU-1:0][FW-1:0] ucmd,
  output logic                is_clr,
  output logic                accept,
  output func_t               func,
  output logic [NU-1:0]       cancel
);

  logic gate_ok;
  logic own_free;

  assign func     = cmd_byte[FW-1:0];
  assign is_clr   = cmd_wr && (func == F_CLR);
  assign gate_ok  = cmd_wr && !is_clr && func_legal(func) && present[cmd_unit]
                    && !(func_writes(func) && wprot[cmd_unit]);
  assign own_free = !active[cmd_unit] || stopping[cmd_unit];
  assign accept   = gate_ok && own_free;

  for (genvar i = 0; i < NU; i++) begin : g_cancel
    assign cancel[i] = accept && (cmd_unit != UW'(i)) && active[i]
                       && (ucmd[i] != F_REW);
  end

endmodule

// File: rtl/tcd_unit_regs.sv
module tcd_unit_regs
  import tcd_pkg::*;
#(
  parameter int NU = 4,
  parameter int UW = $clog2(NU)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  accept,
  input  logic [UW-1:0]         unit,
  input  func_t                 func,
  input  logic [NU-1:0]         cancel,
  input  logic                  seq_upd,
  input  logic [UW-1:0]         seq_unit,
  input  uflags_t               seq_ust,
  input  logic                  seq_done,
  output logic [NU-1:0][FW-1:0] ucmd,
  output logic [NU-1:0][1:0]    ust
);

  for (genvar i = 0; i < NU; i++) begin : g_unit
    logic hit_cmd;
    logic hit_seq;
    assign hit_cmd = accept && (unit == UW'(i));
    assign hit_seq = seq_upd && (seq_unit == UW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ucmd[i] <= '0;
        ust[i]  <= 2'b01;
      end else if (clr) begin
        ucmd[i] <= '0;
        ust[i]  <= {ust[i][1], 1'b1};
      end else if (hit_cmd) begin
        ucmd[i] <= func;
        ust[i]  <= 2'b00;
      end else if (cancel[i]) begin
        ucmd[i] <= '0;
      end else if (hit_seq) begin
        ust[i] <= seq_ust;
        if (seq_done) ucmd[i] <= '0;
      end
    end
  end

endmodule

// File: rtl/tcd_ctl_regs.sv
module tcd_ctl_regs
  import tcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       accept,
  input  func_t      func,
  input  logic       seq_upd,
  input  logic       seq_ctl_we,
  input  logic [7:0] seq_ctl,
  input  logic       seq_xfer_clr,
  output logic [7:0] ctl_sta,
  output logic       xfer
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_sta <= S_BSY;
      xfer    <= 1'b0;
    end else if (clr) begin
      ctl_sta <= S_BSY;
      xfer    <= 1'b0;
    end else if (accept) begin
      ctl_sta <= ctl_init(func);
      xfer    <= func_is_xfer(func);
    end else if (seq_upd) begin
      if (seq_ctl_we)   ctl_sta <= seq_ctl & S_CTL_MASK;
      if (seq_xfer_clr) xfer    <= 1'b0;
    end
  end

endmodule

// File: rtl/tcd_status.sv
module tcd_status
  import tcd_pkg::*;
#(
  parameter int NU = 4,
  parameter int UW = $clog2(NU)
) (
  input  logic [7:0]         ctl_sta,
  input  logic [NU-1:0][1:0] ust,
  input  logic [NU-1:0]      present,
  input  logic [UW-1:0]      sel,
  output logic [7:0]         status
);

  assign status = build_status(ctl_sta, ust[sel], present[sel]);

endmodule

// File: rtl/tape_cmd_decoder.sv
module tape_cmd_decoder
  import tcd_pkg::*;
#(
  parameter int NU = 4,
  parameter int UW = $clog2(NU)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr_i,
  input  logic [UW-1:0]    cmd_unit_i,
  input  logic [7:0]       cmd_byte_i,
  input  logic [NU-1:0]    unit_present_i,
  input  logic [NU-1:0]    unit_wprot_i,
  input  logic [NU-1:0]    unit_active_i,
  input  logic [NU-1:0]    unit_stopping_i,
  input  logic             seq_upd_i,
  input  logic [UW-1:0]    seq_unit_i,
  input  logic [1:0]       seq_ust_i,
  input  logic             seq_done_i,
  input  logic             seq_ctl_we_i,
  input  logic [7:0]       seq_ctl_i,
  input  logic             seq_xfer_clr_i,
  input  logic [UW-1:0]    stat_unit_i,
  output logic [7:0]       status_o,
  output logic             xfer_o,
  output logic             start_o,
  output logic [UW-1:0]    start_unit_o,
  output logic [FW-1:0]    start_func_o,
  output logic [NU-1:0]    cancel_o,
  output logic             clr_o,
  output logic             arm_stb_o,
  output logic [UW-1:0]    arm_unit_o,
  output logic [1:0]       arm_bits_o,
  output logic [NU*FW-1:0] ucmd_o
);

  logic                  clr_w;
  logic                  accept_w;
  func_t                 func_w;
  logic [NU-1:0]         cancel_w;
  logic [NU-1:0][FW-1:0] ucmd_w;
  logic [NU-1:0][1:0]    ust_w;
  logic [7:0]            ctl_w;

  tcd_decode #(.NU(NU), .UW(UW)) u_dec (
    .cmd_wr   (cmd_wr_i),
    .cmd_unit (cmd_unit_i),
    .cmd_byte (cmd_byte_i),
    .present  (unit_present_i),
    .wprot    (unit_wprot_i),
    .active   (unit_active_i),
    .stopping (unit_stopping_i),
    .ucmd     (ucmd_w),
    .is_clr   (clr_w),
    .accept   (accept_w),
    .func     (func_w),
    .cancel   (cancel_w)
  );

  tcd_unit_regs #(.NU(NU), .UW(UW)) u_units (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr_w),
    .accept   (accept_w),
    .unit     (cmd_unit_i),
    .func     (func_w),
    .cancel   (cancel_w),
    .seq_upd  (seq_upd_i),
    .seq_unit (seq_unit_i),
    .seq_ust  (seq_ust_i),
    .seq_done (seq_done_i),
    .ucmd     (ucmd_w),
    .ust      (ust_w)
  );

  tcd_ctl_regs u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr_w),
    .accept       (accept_w),
    .func         (func_w),
    .seq_upd      (seq_upd_i),
    .seq_ctl_we   (seq_ctl_we_i),
    .seq_ctl      (seq_ctl_i),
    .seq_xfer_clr (seq_xfer_clr_i),
    .ctl_sta      (ctl_w),
    .xfer         (xfer_o)
  );

  tcd_status #(.NU(NU), .UW(UW)) u_stat (
    .ctl_sta (ctl_w),
    .ust     (ust_w),
    .present (unit_present_i),
    .sel     (stat_unit_i),
    .status  (status_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o      <= 1'b0;
      start_unit_o <= '0;
      start_func_o <= '0;
      cancel_o     <= '0;
      clr_o        <= 1'b0;
      arm_stb_o    <= 1'b0;
      arm_unit_o   <= '0;
      arm_bits_o   <= '0;
    end else begin
      start_o      <= accept_w;
      start_unit_o <= cmd_unit_i;
      start_func_o <= func_w;
      cancel_o     <= cancel_w;
      clr_o        <= clr_w;
      arm_stb_o    <= cmd_wr_i && !clr_w;
      arm_unit_o   <= cmd_unit_i;
      arm_bits_o   <= cmd_byte_i[7:6];
    end
  end

  assign ucmd_o = ucmd_w;

endmodule

// File: rtl/tape_cmd_decoder_chk.sv
module tape_cmd_decoder_chk
  import tcd_pkg::*;
#(
  parameter int NU = 4,
  parameter int UW = $clog2(NU)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_wr_i,
  input logic [UW-1:0] cmd_unit_i,
  input logic [NU-1:0] unit_present_i,
  input logic [NU-1:0] unit_wprot_i,
  input logic [NU-1:0] unit_active_i,
  input logic [NU-1:0] unit_stopping_i,
  input logic [7:0]    status_o,
  input logic          xfer_o,
  input logic          start_o,
  input logic [UW-1:0] start_unit_o,
  input logic [FW-1:0] start_func_o,
  input logic [NU-1:0] cancel_o,
  input logic          clr_o,
  input logic          arm_stb_o
);

  AST_START_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> func_legal(start_func_o)); // R1

  AST_CLR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |-> (!start_o && !xfer_o && !arm_stb_o)); // R2

  AST_START_NEEDS_MEDIUM: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(unit_present_i[cmd_unit_i])); // R3

  AST_NO_WRITE_PROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_o && func_writes(start_func_o)) |-> !$past(unit_wprot_i[cmd_unit_i])); // R4

  AST_OWN_UNIT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(!unit_active_i[cmd_unit_i] || unit_stopping_i[cmd_unit_i])); // R5

  AST_CANCEL_OTHERS: assert property (@(posedge clk) disable iff (!rst_n)
    (|cancel_o) |-> (start_o && !cancel_o[start_unit_o])); // R6

  AST_XFER_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (xfer_o == func_is_xfer(start_func_o))); // R8

  AST_START_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(cmd_wr_i)); // R9

  AST_DU_HIDES_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[0] |-> ((status_o & 8'h30) == 8'h00)); // R10

endmodule

bind tape_cmd_decoder tape_cmd_decoder_chk #(.NU(NU), .UW(UW)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cmd_wr_i        (cmd_wr_i),
  .cmd_unit_i      (cmd_unit_i),
  .unit_present_i  (unit_present_i),
  .unit_wprot_i    (unit_wprot_i),
  .unit_active_i   (unit_active_i),
  .unit_stopping_i (unit_stopping_i),
  .status_o        (status_o),
  .xfer_o          (xfer_o),
  .start_o         (start_o),
  .start_unit_o    (start_unit_o),
  .start_func_o    (start_func_o),
  .cancel_o        (cancel_o),
  .clr_o           (clr_o),
  .arm_stb_o       (arm_stb_o)
);

// File: tb/sim_tape_cmd_decoder.sv
`timescale 1ns/1ps
module sim_tape_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0;
  logic [1:0]  cmd_unit = '0;
  logic [7:0]  cmd_byte = '0;
  logic [3:0]  present = 4'hF;
  logic [3:0]  wprot = 4'h0;
  logic [3:0]  active = 4'h0;
  logic [3:0]  stopping = 4'h0;
  logic        seq_upd = 1'b0;
  logic [1:0]  seq_unit = '0;
  logic [1:0]  seq_ust = '0;
  logic        seq_done = 1'b0;
  logic        seq_ctl_we = 1'b0;
  logic [7:0]  seq_ctl = '0;
  logic        seq_xfer_clr = 1'b0;
  logic [1:0]  stat_unit = '0;
  logic [7:0]  status;
  logic        xfer, start, clr, arm_stb;
  logic [1:0]  start_unit, arm_unit, arm_bits;
  logic [5:0]  start_func;
  logic [3:0]  cancel;
  logic [23:0] ucmd;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  tape_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr_i(cmd_wr), .cmd_unit_i(cmd_unit),
    .cmd_byte_i(cmd_byte), .unit_present_i(present), .unit_wprot_i(wprot),
    .unit_active_i(active), .unit_stopping_i(stopping), .seq_upd_i(seq_upd),
    .seq_unit_i(seq_unit), .seq_ust_i(seq_ust), .seq_done_i(seq_done),
    .seq_ctl_we_i(seq_ctl_we), .seq_ctl_i(seq_ctl), .seq_xfer_clr_i(seq_xfer_clr),
    .stat_unit_i(stat_unit), .status_o(status), .xfer_o(xfer), .start_o(start),
    .start_unit_o(start_unit), .start_func_o(start_func), .cancel_o(cancel),
    .clr_o(clr), .arm_stb_o(arm_stb), .arm_unit_o(arm_unit), .arm_bits_o(arm_bits),
    .ucmd_o(ucmd)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // expected status byte, from the bit list of R10
  function automatic int exp_stat(int ctl, int eot, int nmtn, int pres);
    int t = ctl;
    if (pres != 0) begin
      if (eot != 0) t |= 'h20;
      if (nmtn != 0) t |= 'h10;
    end else t |= 'h01;
    if ((t & 'hD0) != 0) t |= 'h02;
    return t;
  endfunction

  // writes a command; returns at the negedge where the results are visible
  task automatic cmd(input int u, input int b);
    @(negedge clk);
    cmd_unit = u[1:0]; cmd_byte = b[7:0]; cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic seq(input int u, input int uflags, input int ctlwe, input int ctl,
                     input int xclr, input int done);
    @(negedge clk);
    seq_upd = 1'b1; seq_unit = u[1:0]; seq_ust = uflags[1:0];
    seq_ctl_we = ctlwe[0]; seq_ctl = ctl[7:0]; seq_xfer_clr = xclr[0]; seq_done = done[0];
    @(negedge clk);
    seq_upd = 1'b0; seq_ctl_we = 1'b0; seq_xfer_clr = 1'b0; seq_done = 1'b0;
  endtask

  function automatic bit is_legal(int c);
    return c == 'h11 || c == 'h13 || c == 'h21 || c == 'h22 ||
           c == 'h23 || c == 'h30 || c == 'h38;
  endfunction

  task automatic t_reset;
    stat_unit = 0;
    chk("R11 status", status, exp_stat('h08, 0, 1, 1));
    chk("R11 xfer", xfer, 0);
    chk("R11 start", start, 0);
    chk("R11 ucmd", ucmd, 0);
    present = 4'hE;
    #0.1 chk("R10 DU unit0", status, exp_stat('h08, 0, 0, 0));
    present = 4'hF;
  endtask

  task automatic t_legal;
    seq(0, 0, 1, 'h80, 0, 0);
    for (int c = 0; c < 64; c++) begin
      if (c == 'h20) continue;
      cmd(0, c);
      chk($sformatf("R1 start code %0h", c), start, is_legal(c) ? 1 : 0);
      if (!is_legal(c)) chk("R1 status kept", status, exp_stat('h80, 0, 0, 1));
      else seq(0, 0, 1, 'h80, 0, 0);
    end
  endtask

  task automatic t_init;
    stat_unit = 1;
    cmd(1, 'h21);
    chk("R7 read status", status, 'h08);
    chk("R8 read xfer", xfer, 1);
    chk("R9 unit", start_unit, 1);
    chk("R9 func", start_func, 'h21);
    chk("R9 ucmd", ucmd[11:6], 'h21);
    @(negedge clk);
    chk("R9 single cycle", start, 0);
    cmd(1, 'h22);
    chk("R7 write status", status, 'h00);
    chk("R8 write xfer", xfer, 1);
    cmd(1, 'h23);
    chk("R7 skff status", status, 'h08);
    chk("R8 skff xfer", xfer, 0);
    cmd(1, 'h38);
    chk("R7 rewind status", status, 'h00);
    seq(1, 3, 0, 0, 0, 0);
    cmd(1, 'h30);
    chk("R9 uflags cleared", status, 'h08);
  endtask

  task automatic t_medium;
    present = 4'hB; stat_unit = 2;
    cmd(2, 'h21);
    chk("R3 no start", start, 0);
    chk("R3 DU status", status, exp_stat('h08, 0, 0, 0));
    present = 4'hF;
  endtask

  task automatic t_wprot;
    wprot = 4'h2;
    cmd(1, 'h22); chk("R4 write ignored", start, 0);
    cmd(1, 'h30); chk("R4 wfm ignored", start, 0);
    cmd(1, 'h21); chk("R4 read ok", start, 1);
    wprot = 4'h0;
  endtask

  task automatic t_busy;
    active = 4'h8;
    cmd(3, 'h11); chk("R5 busy ignored", start, 0);
    stopping = 4'h8;
    cmd(3, 'h11); chk("R5 stopping accepted", start, 1);
    active = 4'h0; stopping = 4'h0;
  endtask

  task automatic t_cancel;
    cmd(1, 'h21);
    cmd(2, 'h38);
    active = 4'h6;
    cmd(0, 'h23);
    chk("R6 cancel mask", cancel, 'h2);
    chk("R6 unit1 cleared", ucmd[11:6], 0);
    chk("R6 rewind kept", ucmd[17:12], 'h38);
    chk("R6 own stored", ucmd[5:0], 'h23);
    active = 4'h0;
    cmd(0, 'h13);
    chk("R6 no cancel idle", cancel, 0);
  endtask

  task automatic t_clear;
    seq(1, 2, 1, 'h80, 0, 0);
    present = 4'h7;
    cmd(3, 'h20);
    chk("R2 clr pulse", clr, 1);
    chk("R2 no start", start, 0);
    chk("R2 no arm", arm_stb, 0);
    chk("R2 xfer", xfer, 0);
    chk("R2 ucmd", ucmd, 0);
    stat_unit = 1;
    #0.1 chk("R2 status keeps eot", status, exp_stat('h08, 1, 1, 1));
    present = 4'hF;
    @(negedge clk);
    chk("R2 clr one cycle", clr, 0);
  endtask

  task automatic t_status;
    stat_unit = 0;
    seq(0, 0, 1, 'h40, 0, 0);
    chk("R10 eof exc", status, 'h42);
    seq(0, 2, 1, 'h04, 0, 0);
    chk("R10 eot no exc", status, 'h24);
    seq(0, 0, 1, 'hFF, 0, 0);
    chk("R10 ctl mask", status, 'hCE);
  endtask

  task automatic t_arm;
    cmd(2, 'h91);
    chk("R12 arm stb", arm_stb, 1);
    chk("R12 arm unit", arm_unit, 2);
    chk("R12 arm bits", arm_bits, 2);
    cmd(1, 'h7F);
    chk("R12 arm on illegal", arm_stb, 1);
    chk("R12 arm bits 2", arm_bits, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    chk("watchdog", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_legal;
    t_init;
    t_medium;
    t_wprot;
    t_busy;
    t_cancel;
    t_clear;
    t_status;
    t_arm;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule